// File: doc/BRIEF.md
# Raster Timing Generator for a Character-Clocked Display Controller

This block produces the horizontal and vertical timing of a display raster from the display controller's timing registers, in the form those registers are normally programmed. Horizontal positions are counted in character clocks of `CHAR_PIX` pixels each, and vertical positions in scan lines. Each timing register holds its value with a fixed bias. The upper vertical bits are spread across an overflow register, and the upper horizontal total bits sit in an extension register. The block removes the biases and gathers the scattered bits to rebuild the real values. From them it generates registered horizontal sync, vertical sync, display enable, line-start and frame-start outputs.

All register inputs are live values. The block copies them into a shadow set only when a frame ends, and also while reset is held. A host can therefore rewrite the registers at any time, and the change always takes effect on a frame boundary.

Top module: `crtc_raster_gen`

## Requirements
- R1: While `rst` is high, all five outputs are low and the shadow set loads the live register inputs. In the first cycle after `rst` falls, `frame_start` and `line_start` are high.
- R2: The line length in characters is {`cfg_ext`[5:4], low 6 bits of (`cfg_htotal` + 5)}, and `line_start` is high once every line length × `CHAR_PIX` cycles.
- R3: The frame height in lines is {`cfg_ovf`[5], `cfg_ovf`[0], `cfg_vtotal`} + 2. `frame_start` is high once every frame height × line length × `CHAR_PIX` cycles, and only in a cycle where `line_start` is also high.
- R4: Within a visible line, `disp_en` is high for characters 0 up to and including `cfg_hde`.
- R5: `disp_en` is high only on lines 0 up to and including {`cfg_ovf`[6], `cfg_ovf`[1], `cfg_vde`}.
- R6: `hsync` is high from character `cfg_hss` − 1 up to, but not including, character `cfg_hse` − 1, on every line.
- R7: `vsync` is high for exactly two whole lines, starting at line {`cfg_ovf`[6], `cfg_ovf`[1], `cfg_vde`} + 8. It is never high in the same cycle as `disp_en`.
- R8: A register write made during a frame leaves that frame's timing unchanged. The new values apply from the next `frame_start`.
- R9: `cfg_ext` bits 7:6 and 3:0, and `cfg_ovf` bits 7, 4, 3 and 2, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_htotal | input | 8 | Horizontal total, in characters minus 5 |
| cfg_hde | input | 8 | Last displayed character (count minus 1) |
| cfg_hss | input | 8 | Horizontal sync start character plus 1 |
| cfg_hse | input | 8 | Horizontal sync end character plus 1 |
| cfg_vtotal | input | 8 | Vertical total, lines minus 2, bits 7:0 |
| cfg_vde | input | 8 | Last displayed line, bits 7:0 |
| cfg_ovf | input | 8 | Overflow: bit0 vtotal b8, bit1 vde b8, bit5 vtotal b9, bit6 vde b9 |
| cfg_ext | input | 8 | Extension: bits 5:4 are horizontal total bits 7:6 |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Active display area |
| line_start | output | 1 | First pixel of each line |
| frame_start | output | 1 | First pixel of each frame |

## Verification
The bench builds the block with `CHAR_PIX` = 2. This keeps a 514-line frame to a few thousand cycles, so the bench can exercise frame heights that use vertical bit 8 and bit 9 and a 66-character line that depends on the extension bits. One table vector sets every ignored overflow and extension bit and must give the same timing as a plain vector. Directed tests cover reset in the middle of a frame and a register rewrite in the middle of a frame.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W        = 8;
  localparam int CHR_W        = 8;
  localparam int LN_W         = 11;
  localparam int H_TOTAL_BIAS = 5;
  localparam int V_TOTAL_BIAS = 2;
  localparam int VSYNC_GAP    = 8;
  localparam int VSYNC_LINES  = 2;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [CHR_W-1:0] chr_t;
  typedef logic [LN_W-1:0]  line_t;

  typedef struct packed {
    reg_t htotal;
    reg_t hde;
    reg_t hss;
    reg_t hse;
    reg_t vtotal;
    reg_t vde;
    reg_t ovf;
    reg_t ext;
  } crtc_regs_t;

  typedef struct packed {
    chr_t  h_last;
    chr_t  h_de_last;
    chr_t  h_ss;
    chr_t  h_se;
    line_t v_last;
    line_t v_disp;
    line_t vs_start;
    line_t vs_end;
  } timing_t;
endpackage

// File: rtl/crtc_decode.sv
module crtc_decode
  import crtc_pkg::*;
(
  input  crtc_regs_t regs,
  output timing_t    tm
);
  reg_t  hsum;
  chr_t  hchars;
  line_t vt_raw;
  line_t vde_raw;
  logic  unused_bits;

  // Horizontal total: biased low bits plus the two extension bits on top.
  assign hsum    = regs.htotal + reg_t'(H_TOTAL_BIAS);
  assign hchars  = {regs.ext[5:4], hsum[5:0]};
  // Vertical values gathered from the overflow register.
  assign vt_raw  = line_t'({regs.ovf[5], regs.ovf[0], regs.vtotal});
  assign vde_raw = line_t'({regs.ovf[6], regs.ovf[1], regs.vde});

  always_comb begin
    tm.h_last    = (hchars == '0) ? '0 : hchars - chr_t'(1);
    tm.h_de_last = regs.hde;
    tm.h_ss      = regs.hss - chr_t'(1);
    tm.h_se      = regs.hse - chr_t'(1);
    tm.v_last    = vt_raw + line_t'(V_TOTAL_BIAS - 1);
    tm.v_disp    = vde_raw + line_t'(1);
    tm.vs_start  = vde_raw + line_t'(VSYNC_GAP);
    tm.vs_end    = vde_raw + line_t'(VSYNC_GAP + VSYNC_LINES);
  end

  assign unused_bits = ^{regs.ext[7:6], regs.ext[3:0], regs.ovf[7],
                         regs.ovf[4:2], hsum[7:6]};
endmodule

// File: rtl/crtc_shadow.sv
module crtc_shadow
  import crtc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  timing_t d,
  output timing_t q
);
  always_ff @(posedge clk) begin
    if (rst || load) q <= d;
  end
endmodule

// File: rtl/crtc_counters.sv
module crtc_counters
  import crtc_pkg::*;
#(
  parameter int CHAR_PIX = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  timing_t tm,
  output logic    pix_first,
  output chr_t    chr,
  output line_t   line,
  output logic    frame_end
);
  logic pix_last;
  logic chr_end;

  generate
    if (CHAR_PIX > 1) begin : g_pix
      localparam int PIX_W = $clog2(CHAR_PIX);
      logic [PIX_W-1:0] pix;
      always_ff @(posedge clk) begin
        if (rst)           pix <= '0;
        else if (pix_last) pix <= '0;
        else               pix <= pix + PIX_W'(1);
      end
      assign pix_last  = (pix == PIX_W'(CHAR_PIX - 1));
      assign pix_first = (pix == '0);
    end else begin : g_nopix
      assign pix_last  = 1'b1;
      assign pix_first = 1'b1;
    end
  endgenerate

  assign chr_end   = pix_last && (chr == tm.h_last);
  assign frame_end = chr_end && (line == tm.v_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      chr  <= '0;
      line <= '0;
    end else if (pix_last) begin
      if (chr == tm.h_last) begin
        chr  <= '0;
        line <= (line == tm.v_last) ? '0 : line + line_t'(1);
      end else begin
        chr <= chr + chr_t'(1);
      end
    end
  end
endmodule

// File: rtl/crtc_strobes.sv
module crtc_strobes
  import crtc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  timing_t tm,
  input  logic    pix_first,
  input  chr_t    chr,
  input  line_t   line,
  output logic    hsync,
  output logic    vsync,
  output logic    disp_en,
  output logic    line_start,
  output logic    frame_start
);
  logic at_line_head;
  assign at_line_head = pix_first && (chr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      disp_en     <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      hsync       <= (chr >= tm.h_ss) && (chr < tm.h_se);
      vsync       <= (line >= tm.vs_start) && (line < tm.vs_end);
      disp_en     <= (chr <= tm.h_de_last) && (line < tm.v_disp);
      line_start  <= at_line_head;
      frame_start <= at_line_head && (line == '0);
    end
  end
endmodule

// File: rtl/crtc_raster_gen.sv
module crtc_raster_gen
  import crtc_pkg::*;
#(
  parameter int CHAR_PIX = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cfg_htotal,
  input  logic [7:0] cfg_hde,
  input  logic [7:0] cfg_hss,
  input  logic [7:0] cfg_hse,
  input  logic [7:0] cfg_vtotal,
  input  logic [7:0] cfg_vde,
  input  logic [7:0] cfg_ovf,
  input  logic [7:0] cfg_ext,
  output logic       hsync,
  output logic       vsync,
  output logic       disp_en,
  output logic       line_start,
  output logic       frame_start
);
  crtc_regs_t live_regs;
  timing_t    live_tm;
  timing_t    act_tm;
  logic       pix_first;
  chr_t       chr;
  line_t      line;
  logic       frame_end;

  assign live_regs = '{htotal: cfg_htotal, hde: cfg_hde, hss: cfg_hss,
                       hse: cfg_hse, vtotal: cfg_vtotal, vde: cfg_vde,
                       ovf: cfg_ovf, ext: cfg_ext};

  crtc_decode u_decode (
    .regs (live_regs),
    .tm   (live_tm)
  );

  crtc_shadow u_shadow (
    .clk  (clk),
    .rst  (rst),
    .load (frame_end),
    .d    (live_tm),
    .q    (act_tm)
  );

  crtc_counters #(.CHAR_PIX(CHAR_PIX)) u_counters (
    .clk       (clk),
    .rst       (rst),
    .tm        (act_tm),
    .pix_first (pix_first),
    .chr       (chr),
    .line      (line),
    .frame_end (frame_end)
  );

  crtc_strobes u_strobes (
    .clk         (clk),
    .rst         (rst),
    .tm          (act_tm),
    .pix_first   (pix_first),
    .chr         (chr),
    .line        (line),
    .hsync       (hsync),
    .vsync       (vsync),
    .disp_en     (disp_en),
    .line_start  (line_start),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/crtc_raster_chk.sv
module crtc_raster_chk #(
  parameter int CHAR_PIX = 8
) (
  input logic clk,
  input logic rst,
  input logic hsync,
  input logic vsync,
  input logic disp_en,
  input logic line_start,
  input logic frame_start
);
  logic rst_seen_q = 1'b0;

  // R1: one clock after reset was sampled, every output is low.
  always @(posedge clk) begin
    if (rst_seen_q) begin
      assert_reset_quiet_R1: assert (!hsync && !vsync && !disp_en &&
                                     !line_start && !frame_start)
        else $error("outputs active after reset");
    end
    rst_seen_q <= rst;
  end

  assert_frame_on_line_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);

  assert_vsync_blank_R7: assert property (@(posedge clk) disable iff (rst)
    vsync |-> !disp_en);

  generate
    if (CHAR_PIX > 1) begin : g_pulse
      assert_line_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);
      assert_frame_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);
    end
  endgenerate
endmodule

bind crtc_raster_gen crtc_raster_chk #(.CHAR_PIX(CHAR_PIX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hsync       (hsync),
  .vsync       (vsync),
  .disp_en     (disp_en),
  .line_start  (line_start),
  .frame_start (frame_start)
);

// File: tb/crtc_raster_gen_tb.sv
module crtc_raster_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2;

  typedef struct packed {
    logic [7:0] ht, hde, hss, hse, vt, vde, ovf, ext;
    int h, d, s, n, v, l, vs;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd7,   8'd7,  8'd9,  8'd11, 8'd22,   8'd11,   8'h10, 8'h00, 12, 8,  8,  2, 24,  12,  19},
    '{8'd11,  8'd9,  8'd12, 8'd15, 8'd28,   8'd15,   8'h10, 8'h00, 16, 10, 11, 3, 30,  16,  23},
    '{8'd1,   8'd3,  8'd5,  8'd6,  8'h20,   8'h04,   8'h13, 8'h00, 6,  4,  4,  1, 290, 261, 268},
    '{8'hFD,  8'd63, 8'd65, 8'd66, 8'd6,    8'd3,    8'h10, 8'hD0, 66, 64, 64, 1, 8,   4,   -1},
    '{8'd1,   8'd2,  8'd3,  8'd5,  8'h00,   8'h00,   8'h70, 8'h00, 6,  3,  2,  2, 514, 513, -1},
    '{8'd7,   8'd7,  8'd9,  8'd11, 8'd22,   8'd11,   8'h9C, 8'hCF, 12, 8,  8,  2, 24,  12,  19}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_htotal, cfg_hde, cfg_hss, cfg_hse, cfg_vtotal, cfg_vde, cfg_ovf, cfg_ext;
  logic hsync, vsync, disp_en, line_start, frame_start;

  int checks = 0;
  int errors = 0;
  int m_frame, m_line, m_lines, m_de, m_de0, m_de_lines, m_hs_first, m_hs0, m_vs_line, m_vs, m_ovl;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_raster_gen #(.CHAR_PIX(P)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_htotal(cfg_htotal), .cfg_hde(cfg_hde), .cfg_hss(cfg_hss), .cfg_hse(cfg_hse),
    .cfg_vtotal(cfg_vtotal), .cfg_vde(cfg_vde), .cfg_ovf(cfg_ovf), .cfg_ext(cfg_ext),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .line_start(line_start), .frame_start(frame_start)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic apply(input int i);
    cfg_htotal = VECS[i].ht;  cfg_hde = VECS[i].hde;
    cfg_hss    = VECS[i].hss; cfg_hse = VECS[i].hse;
    cfg_vtotal = VECS[i].vt;  cfg_vde = VECS[i].vde;
    cfg_ovf    = VECS[i].ovf; cfg_ext = VECS[i].ext;
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!frame_start);
  endtask

  // Called at a negedge where frame_start is high; returns at the next one.
  task automatic measure();
    int cyc = 0;
    int li = -1;
    int last_de_line = -1;
    m_line = 0; m_lines = 0; m_de = 0; m_de0 = 0; m_de_lines = 0;
    m_hs_first = -1; m_hs0 = 0; m_vs_line = -1; m_vs = 0; m_ovl = 0;
    forever begin
      if (line_start) begin
        li++;
        m_lines++;
        if (li == 1) m_line = cyc;
      end
      if (disp_en) begin
        m_de++;
        if (li == 0) m_de0++;
        if (last_de_line != li) begin
          m_de_lines++;
          last_de_line = li;
        end
      end
      if (hsync && li == 0) begin
        if (m_hs_first < 0) m_hs_first = cyc;
        m_hs0++;
      end
      if (vsync) begin
        m_vs++;
        if (m_vs_line < 0) m_vs_line = li;
      end
      if (vsync && disp_en) m_ovl++;
      @(negedge clk);
      cyc++;
      if (frame_start) break;
    end
    m_frame = cyc;
  endtask

  task automatic check_vec(input int i);
    int lp = VECS[i].h * P;
    chk($sformatf("R3 vec%0d frame length", i), m_frame, lp * VECS[i].v);
    chk($sformatf("R2 vec%0d line length", i), m_line, lp);
    chk($sformatf("R3 vec%0d line count", i), m_lines, VECS[i].v);
    chk($sformatf("R4 vec%0d de cycles in line 0", i), m_de0, VECS[i].d * P);
    chk($sformatf("R5 vec%0d lines with de", i), m_de_lines, VECS[i].l);
    chk($sformatf("R5 vec%0d de total", i), m_de, VECS[i].d * P * VECS[i].l);
    chk($sformatf("R6 vec%0d hsync start", i), m_hs_first, VECS[i].s * P);
    chk($sformatf("R6 vec%0d hsync width", i), m_hs0, VECS[i].n * P);
    chk($sformatf("R7 vec%0d vsync line", i), m_vs_line, VECS[i].vs);
    chk($sformatf("R7 vec%0d vsync cycles", i), m_vs, (VECS[i].vs < 0) ? 0 : 2 * lp);
    chk($sformatf("R7 vec%0d vsync with de", i), m_ovl, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    apply(0);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet while in reset
    chk("R1 outputs in reset", int'({hsync, vsync, disp_en, line_start, frame_start}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 frame_start after release", int'(frame_start), 1);
    chk("R1 line_start after release", int'(line_start), 1);
    measure();
    check_vec(0);

    for (int i = 1; i < NVEC; i++) begin
      apply(i);
      wait_frame();
      measure();
      check_vec(i);
    end
    // R9: ignored overflow/extension bits leave vector 0 timing intact
    chk("R9 frame length with ignored bits set", m_frame, VECS[0].h * P * VECS[0].v);

    // R8: mid-frame rewrite does not alter the running frame
    begin
      int cyc = 0;
      repeat (30) begin
        @(negedge clk);
        cyc++;
      end
      apply(1);
      while (!frame_start) begin
        @(negedge clk);
        cyc++;
      end
      chk("R8 running frame keeps old length", cyc, VECS[5].h * P * VECS[5].v);
      measure();
      chk("R8 next frame uses new length", m_frame, VECS[1].h * P * VECS[1].v);
    end

    // R1: reset in mid-frame, registers taken straight from inputs
    repeat (50) @(negedge clk);
    rst = 1'b1;
    apply(0);
    @(negedge clk);
    chk("R1 outputs after mid-frame reset", int'({hsync, vsync, disp_en, line_start, frame_start}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 frame_start after second release", int'(frame_start), 1);
    measure();
    chk("R1 frame length after reset reload", m_frame, VECS[0].h * P * VECS[0].v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule